// File: doc/BRIEF.md
# Four-Beat Double-Rate Split-Port Memory

This block is a synchronous memory with one read port and one write port that work independently. Both ports can take a request at the same clock edge. Every access moves a fixed group of four words. The caller supplies only a group index. The block generates the two low word-address bits itself, starting at 0 and counting up by one for each beat. Each data lane carries two beats per clock period: the low half of a lane word is the beat on the rising edge, and the high half is the beat on the falling edge. The core is modelled in a single clock domain, so a cycle holds two beats. A burst of four therefore takes two cycles on either port.

A write request carries only the group index. Its data pairs arrive on the two edges after the request. Each beat has its own active-low byte mask, captured with that beat. The group is written to the array in one step, once the last pair has been captured.

A read request returns its four words through a registered output stage, two words per cycle, and `rd_valid` marks them. The two pipelines are coherent: a read observes every write accepted at an earlier edge, even a write whose beats are still arriving.

Neither stream can be stalled by the consumer. Each port has a `*_ready` output that is high when a request at the next edge would be accepted. A request made while `*_ready` is low is dropped. Read data has no ready input, because the consumer must take the two valid cycles as they come.

Top module: `burst4_dual_mem`

## Requirements
- R1: A read returns four words in exactly two consecutive `rd_valid` cycles. Within each cycle, bits [WORD_W-1:0] of `rd_pair` hold the earlier beat.
- R2: The four beats of a burst map to word addresses `{group,2'b00}`, `{group,2'b01}`, `{group,2'b10}` and `{group,2'b11}`, in that order.
- R3: A read accepted at edge R drives its first pair (words 0 and 1) after edge R+2 and its second pair (words 2 and 3) after edge R+3.
- R4: `rd_sel_n` and `wr_sel_n` are active low. While a select is high, the port takes no request, whatever the group and data inputs carry.
- R5: For a write accepted at edge W, words 0 and 1 are taken from `wr_pair` at edge W+1 and words 2 and 3 at edge W+2. Bit b of `wr_ben_n` masks byte b of the pair (bits 0..LANES-1 belong to the lower word), and low means write. A masked byte keeps its old value.
- R6: A read and a write may both be accepted at the same edge. That read returns the contents from before that write.
- R7: A read accepted at edge R returns data that includes every write accepted before R, including writes still receiving beats when the read fetches.
- R8: After a port accepts a request, its `*_ready` is low for one cycle, and a request made during that cycle is ignored.
- R9: While `rst_n` is low and right after reset, `rd_valid` is 0, `rd_pair` is 0, and both ready outputs are 1.
- R10: `rd_pair` is all zeros in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one data pair per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read request, active low |
| rd_grp | input | GRP_W | Group index of the read |
| rd_ready | output | 1 | Read port can take a request at the next edge |
| wr_sel_n | input | 1 | Write request, active low |
| wr_grp | input | GRP_W | Group index of the write |
| wr_ready | output | 1 | Write port can take a request at the next edge |
| wr_pair | input | 2*WORD_W | Two write beats, earlier beat in the low half |
| wr_ben_n | input | 2*LANES | Per-beat byte write masks, active low |
| rd_valid | output | 1 | `rd_pair` carries read beats |
| rd_pair | output | 2*WORD_W | Two read beats, earlier beat in the low half |

## Verification
A read fetch and a write completion can fall in the same cycle, and so can read and write requests. The bench provokes both by issuing reads to a group one or two cycles after a byte-masked write to that same group, and by issuing a read and a write at the same edge. It then runs a long stretch of random traffic confined to four groups, so these overlaps occur many times. A reference array in the bench is updated at the moment a write is accepted. Each read takes its snapshot before any same-edge write is applied, which gives the expected pair for every valid cycle without modelling the pipeline.

// File: rtl/burst4_pkg.sv
package burst4_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEATS_PER_CYC = 2;
  localparam int LOW_BITS = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    WPH_IDLE   = 2'd0,
    WPH_FIRST  = 2'd1,
    WPH_SECOND = 2'd2
  } wr_phase_t;
endpackage

// File: rtl/burst4_array.sv
module burst4_array
  import burst4_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int WORD_W = 16,
  parameter int LANES  = 2
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [GRP_W-1:0]               wgrp,
  input  logic [BURST_LEN*WORD_W-1:0]    wdata,
  input  logic [BURST_LEN*LANES-1:0]     wben_n,
  input  logic [GRP_W-1:0]               rgrp,
  output logic [BURST_LEN*WORD_W-1:0]    rdata
);
  localparam int BYTE_W = WORD_W / LANES;
  localparam int DEPTH  = 1 << (GRP_W + LOW_BITS);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int w = 0; w < BURST_LEN; w++) begin
        for (int b = 0; b < LANES; b++) begin
          if (!wben_n[w*LANES+b])
            mem[{wgrp, LOW_BITS'(w)}][b*BYTE_W +: BYTE_W] <= wdata[w*WORD_W + b*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  for (genvar w = 0; w < BURST_LEN; w++) begin : g_rd
    assign rdata[w*WORD_W +: WORD_W] = mem[{rgrp, LOW_BITS'(w)}];
  end
endmodule

// File: rtl/burst4_wr_capture.sv
module burst4_wr_capture
  import burst4_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int WORD_W = 16,
  parameter int LANES  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_sel_n,
  input  logic [GRP_W-1:0]                    wr_grp,
  input  logic [BEATS_PER_CYC*WORD_W-1:0]     wr_pair,
  input  logic [BEATS_PER_CYC*LANES-1:0]      wr_ben_n,
  output logic                                wr_ready,
  output logic                                commit,
  output logic [GRP_W-1:0]                    pend_grp,
  output logic [BURST_LEN*WORD_W-1:0]         full_data,
  output logic [BURST_LEN*LANES-1:0]          full_ben_n
);
  localparam int PAIR_W = BEATS_PER_CYC * WORD_W;
  localparam int PMSK_W = BEATS_PER_CYC * LANES;

  wr_phase_t          phase;
  logic               wr_acc;
  logic [PAIR_W-1:0]  first_pair;
  logic [PMSK_W-1:0]  first_ben_n;

  assign wr_ready = (phase != WPH_FIRST);
  assign wr_acc   = !wr_sel_n && wr_ready;
  assign commit   = (phase == WPH_SECOND);

  assign full_data  = {wr_pair, first_pair};
  assign full_ben_n = {wr_ben_n, first_ben_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= WPH_IDLE;
      pend_grp    <= '0;
      first_pair  <= '0;
      first_ben_n <= '1;
    end else begin
      if (wr_acc) begin
        phase    <= WPH_FIRST;
        pend_grp <= wr_grp;
      end else if (phase == WPH_FIRST) begin
        phase <= WPH_SECOND;
      end else begin
        phase <= WPH_IDLE;
      end
      if (phase == WPH_FIRST) begin
        first_pair  <= wr_pair;
        first_ben_n <= wr_ben_n;
      end
    end
  end

  // R5
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_acc, 2) |-> commit);

  // R8
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc);
endmodule

// File: rtl/burst4_rd_pipe.sv
module burst4_rd_pipe
  import burst4_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int WORD_W = 16,
  parameter int LANES  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_sel_n,
  input  logic [GRP_W-1:0]                   rd_grp,
  output logic                               rd_ready,
  output logic [GRP_W-1:0]                   fetch_grp,
  input  logic [BURST_LEN*WORD_W-1:0]        arr_data,
  input  logic                               fwd_live,
  input  logic [GRP_W-1:0]                   fwd_grp,
  input  logic [BURST_LEN*WORD_W-1:0]        fwd_data,
  input  logic [BURST_LEN*LANES-1:0]         fwd_ben_n,
  output logic                               rd_valid,
  output logic [BEATS_PER_CYC*WORD_W-1:0]    rd_pair
);
  localparam int BYTE_W  = WORD_W / LANES;
  localparam int GROUP_W = BURST_LEN * WORD_W;
  localparam int PAIR_W  = BEATS_PER_CYC * WORD_W;
  localparam int NBYTES  = BURST_LEN * LANES;

  logic               busy, rd_acc;
  logic               s0_v, s1_v, hi_pend;
  logic               fwd_hit;
  logic [GROUP_W-1:0] merged, s1_data;

  assign rd_ready = !busy;
  assign rd_acc   = !rd_sel_n && !busy;
  assign fwd_hit  = fwd_live && (fwd_grp == fetch_grp);

  for (genvar b = 0; b < NBYTES; b++) begin : g_merge
    assign merged[b*BYTE_W +: BYTE_W] = (fwd_hit && !fwd_ben_n[b])
                                        ? fwd_data[b*BYTE_W +: BYTE_W]
                                        : arr_data[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      fetch_grp <= '0;
      s0_v      <= 1'b0;
      s1_v      <= 1'b0;
      s1_data   <= '0;
      hi_pend   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_pair   <= '0;
    end else begin
      busy <= rd_acc;
      s0_v <= rd_acc;
      if (rd_acc) fetch_grp <= rd_grp;
      s1_v <= s0_v;
      if (s0_v) s1_data <= merged;
      if (s1_v) begin
        rd_valid <= 1'b1;
        rd_pair  <= s1_data[PAIR_W-1:0];
        hi_pend  <= 1'b1;
      end else if (hi_pend) begin
        rd_valid <= 1'b1;
        rd_pair  <= s1_data[GROUP_W-1:PAIR_W];
        hi_pend  <= 1'b0;
      end else begin
        rd_valid <= 1'b0;
        rd_pair  <= '0;
      end
    end
  end

  // R3
  rd_lat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc, 3) |-> rd_valid);

  // R3
  rd_lat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc, 4) |-> rd_valid);

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_pair == '0));

  // R8
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);
endmodule

// File: rtl/burst4_dual_mem.sv
module burst4_dual_mem
  import burst4_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int WORD_W = 16,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_sel_n,
  input  logic [GRP_W-1:0]      rd_grp,
  output logic                  rd_ready,
  input  logic                  wr_sel_n,
  input  logic [GRP_W-1:0]      wr_grp,
  output logic                  wr_ready,
  input  logic [2*WORD_W-1:0]   wr_pair,
  input  logic [2*LANES-1:0]    wr_ben_n,
  output logic                  rd_valid,
  output logic [2*WORD_W-1:0]   rd_pair
);
  localparam int GROUP_W = BURST_LEN * WORD_W;
  localparam int GMASK_W = BURST_LEN * LANES;

  logic               commit;
  logic [GRP_W-1:0]   pend_grp, fetch_grp;
  logic [GROUP_W-1:0] full_data, arr_data;
  logic [GMASK_W-1:0] full_ben_n;

  burst4_wr_capture #(.GRP_W(GRP_W), .WORD_W(WORD_W), .LANES(LANES)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel_n   (wr_sel_n),
    .wr_grp     (wr_grp),
    .wr_pair    (wr_pair),
    .wr_ben_n   (wr_ben_n),
    .wr_ready   (wr_ready),
    .commit     (commit),
    .pend_grp   (pend_grp),
    .full_data  (full_data),
    .full_ben_n (full_ben_n)
  );

  burst4_array #(.GRP_W(GRP_W), .WORD_W(WORD_W), .LANES(LANES)) u_arr (
    .clk    (clk),
    .we     (commit),
    .wgrp   (pend_grp),
    .wdata  (full_data),
    .wben_n (full_ben_n),
    .rgrp   (fetch_grp),
    .rdata  (arr_data)
  );

  burst4_rd_pipe #(.GRP_W(GRP_W), .WORD_W(WORD_W), .LANES(LANES)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_sel_n  (rd_sel_n),
    .rd_grp    (rd_grp),
    .rd_ready  (rd_ready),
    .fetch_grp (fetch_grp),
    .arr_data  (arr_data),
    .fwd_live  (commit),
    .fwd_grp   (pend_grp),
    .fwd_data  (full_data),
    .fwd_ben_n (full_ben_n),
    .rd_valid  (rd_valid),
    .rd_pair   (rd_pair)
  );
endmodule

// File: tb/sim_burst4_dual_mem.sv
module sim_burst4_dual_mem;
  localparam int GW = 6;
  localparam int WW = 16;
  localparam int LN = 2;
  localparam int BW = WW / LN;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [GW-1:0]   rd_grp = '0, wr_grp = '0;
  logic [2*WW-1:0] wr_pair = '0;
  logic [2*LN-1:0] wr_ben_n = '1;
  logic            rd_ready, wr_ready, rd_valid;
  logic [2*WW-1:0] rd_pair;

  burst4_dual_mem #(.GRP_W(GW), .WORD_W(WW), .LANES(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_grp(rd_grp), .rd_ready(rd_ready),
    .wr_sel_n(wr_sel_n), .wr_grp(wr_grp), .wr_ready(wr_ready), .wr_pair(wr_pair),
    .wr_ben_n(wr_ben_n), .rd_valid(rd_valid), .rd_pair(rd_pair)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R9";

  logic [WW-1:0]   ref_mem [0:(1<<(GW+2))-1];
  bit              exp_v [int];
  logic [2*WW-1:0] exp_d [int];
  logic [2*WW-1:0] beat_d [int];
  logic [2*LN-1:0] beat_m [int];
  bit              m_rbusy = 1'b0, m_wbusy = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic check_outputs();
    bit ev;
    logic [2*WW-1:0] ed;
    ev = exp_v.exists(cyc);
    ed = ev ? exp_d[cyc] : '0;
    // R1 R3: valid in exactly the two expected cycles
    chk("R3", "rd_valid", 64'(rd_valid), 64'(ev));
    if (ev) chk(tag, "rd_pair", 64'(rd_pair), 64'(ed));
    else    chk("R10", "rd_pair idle", 64'(rd_pair), 64'(0));
    // R8
    chk("R8", "rd_ready", 64'(rd_ready), 64'(!m_rbusy));
    chk("R8", "wr_ready", 64'(wr_ready), 64'(!m_wbusy));
    if (ev) begin exp_v.delete(cyc); exp_d.delete(cyc); end
  endtask

  task automatic drive(input bit rq, input int ra, input bit wq, input int wa,
                       input logic [4*WW-1:0] wd, input logic [4*LN-1:0] wm);
    bit racc, wacc;
    int k;
    k = cyc;
    racc = rq && !m_rbusy;
    wacc = wq && !m_wbusy;
    if (racc) begin
      // R2: word order within the group; R6: snapshot before same-edge write
      exp_v[k+3] = 1'b1;
      exp_d[k+3] = {ref_mem[ra*4+1], ref_mem[ra*4]};
      exp_v[k+4] = 1'b1;
      exp_d[k+4] = {ref_mem[ra*4+3], ref_mem[ra*4+2]};
    end
    if (wacc) begin
      beat_d[k+1] = wd[2*WW-1:0];
      beat_m[k+1] = wm[2*LN-1:0];
      beat_d[k+2] = wd[4*WW-1:2*WW];
      beat_m[k+2] = wm[4*LN-1:2*LN];
      for (int w = 0; w < 4; w++)
        for (int b = 0; b < LN; b++)
          if (!wm[w*LN+b]) ref_mem[wa*4+w][b*BW +: BW] = wd[w*WW + b*BW +: BW];
    end
    m_rbusy = racc;
    m_wbusy = wacc;
    rd_sel_n = !rq;
    wr_sel_n = !wq;
    rd_grp   = GW'(rq ? ra : $urandom);
    wr_grp   = GW'(wq ? wa : $urandom);
    if (beat_d.exists(k)) begin
      wr_pair  = beat_d[k];
      wr_ben_n = beat_m[k];
      beat_d.delete(k);
      beat_m.delete(k);
    end else begin
      wr_pair  = 2*WW'($urandom);
      wr_ben_n = 2*LN'($urandom);
    end
  endtask

  task automatic step(input bit rq, input int ra, input bit wq, input int wa,
                      input logic [4*WW-1:0] wd, input logic [4*LN-1:0] wm);
    @(negedge clk);
    check_outputs();
    drive(rq, ra, wq, wa, wd, wm);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '1);
  endtask

  function automatic logic [4*WW-1:0] rnd_group();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs during reset
    chk("R9", "rd_valid in reset", 64'(rd_valid), 64'(0));
    chk("R9", "rd_pair in reset", 64'(rd_pair), 64'(0));
    chk("R9", "rd_ready in reset", 64'(rd_ready), 64'(1));
    chk("R9", "wr_ready in reset", 64'(wr_ready), 64'(1));
    rst_n = 1'b1;

    // prefill groups 0..3 and the top group with full writes
    tag = "R5";
    for (int g = 0; g < 4; g++) begin
      step(0, 0, 1, g, rnd_group(), '0);
      idle(1);
    end
    step(0, 0, 1, (1 << GW) - 1, rnd_group(), '0);
    idle(4);

    // R2 R3: isolated reads, including the top group
    tag = "R2";
    step(1, 1, 0, 0, '0, '1); idle(5);
    step(1, (1 << GW) - 1, 0, 0, '0, '1); idle(5);

    // R5: masked write, read after it fully commits
    tag = "R5";
    step(0, 0, 1, 2, rnd_group(), 8'b1010_0110); idle(4);
    step(1, 2, 0, 0, '0, '1); idle(5);

    // R7: read one edge after a masked write to the same group (beats in flight)
    tag = "R7";
    step(0, 0, 1, 3, rnd_group(), 8'b0110_1001);
    step(1, 3, 0, 0, '0, '1); idle(5);
    // R7: read two edges after the write
    step(0, 0, 1, 1, rnd_group(), 8'b1100_0011); idle(1);
    step(1, 1, 0, 0, '0, '1); idle(5);

    // R6: read and write to the same group at the same edge
    tag = "R6";
    step(1, 0, 1, 0, rnd_group(), 8'b0000_0000); idle(1);
    step(1, 0, 0, 0, '0, '1); idle(5);

    // R8: back-to-back requests, the second is ignored
    tag = "R8";
    step(1, 1, 1, 2, rnd_group(), '0);
    step(1, 2, 1, 1, rnd_group(), '0);
    idle(6);
    step(1, 2, 0, 0, '0, '1); idle(5);

    // R4: selects high, address and data toggling
    tag = "R4";
    for (int i = 0; i < 12; i++) step(0, i % 4, 0, i % 4, rnd_group(), '0);
    step(1, 1, 0, 0, '0, '1); idle(5);

    // R1 R7: random overlapping traffic on four groups
    tag = "R1";
    for (int i = 0; i < 4000; i++)
      step(($urandom % 3) != 0, $urandom % 4, ($urandom % 3) != 0, $urandom % 4,
           rnd_group(), 8'($urandom));
    tag = "R7";
    for (int i = 0; i < 2000; i++)
      step(($urandom % 2) != 0, $urandom % 2, ($urandom % 2) != 0, $urandom % 2,
           rnd_group(), 8'($urandom));
    idle(8);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule